// File: doc/BRIEF.md
# DDR Mode Register Programming Sequencer

This block sits in a DDR SDRAM controller and writes the memory's two mode registers in the correct order. A one-cycle `start` pulse latches the requested settings: burst length, burst type, CAS latency, DLL disable, drive strength and DLL reset. If the bank-idle input is high and every code is legal, the block drives a fixed command sequence on the command, bank and address pins. The sequence is a precharge-all command, a wait for precharge recovery, an extended-register write, a register-set gap, a base-register write and a final gap. At the end, `done` pulses for one cycle.

If a code is reserved, or the banks are not idle when `start` arrives, the block issues no command. It pulses `error` for one cycle and stays idle. The interface carries only control and status, so no valid/ready handshake is used. `start` is a single pulse with no back-pressure: a pulse that arrives while `busy` is high is dropped.

Between sequences the pins drive a deselect: CS# high, RAS#, CAS# and WE# high, and bank and address zero.

Top module: `mrs_seq`

## Requirements
- R1: While reset is held, and right after it, the pins show deselect (cs_n, ras_n, cas_n and we_n all 1, ba=0, addr=0), and busy, done and error are all 0.
- R2: In the cycle after an accepted start, the pins carry precharge-all: cs_n=0, ras_n=0, cas_n=1, we_n=0, ba=0, addr=0x400 (only A10 set). busy is 1.
- R3: The extended-register write comes exactly TRP_CYC cycles after precharge-all (default 3). Every cycle between them is a NOP: cs_n=0, ras_n=1, cas_n=1, we_n=1, ba=0, addr=0.
- R4: The extended-register write has cs_n, ras_n, cas_n and we_n all 0 and ba=2'b01. addr[0] is the DLL-disable input, addr[1] is the drive-strength input (1 = half), and all other address bits are 0.
- R5: The base-register write comes TMRD_CYC cycles (default 2) after the extended write, with NOPs between them. It has all four command pins at 0 and ba=2'b00. addr = {4'b0, dll_rst, 1'b0, cl_code, burst_il, bl_code}: burst length on A2:A0, burst type on A3, CAS latency on A6:A4, A7=0 and DLL reset on A8.
- R6: After the base write come NOPs for TMRD_CYC-1 cycles. Then done is 1 for exactly one cycle with busy 0 and the pins deselected, and after that the block is idle.
- R7: A burst-length code other than 001, 010 or 011 at start makes error 1 for one cycle in the next cycle. No command is issued and busy stays 0.
- R8: A CAS-latency code other than 010, 011 or 110 at start makes error 1 for one cycle in the next cycle. No command is issued.
- R9: If banks_idle is 0 at start, error is 1 for one cycle in the next cycle and no command is issued.
- R10: A start pulse while busy is 1 is ignored. The running sequence keeps its timing, and no second sequence follows.
- R11: Settings are sampled only in the cycle start is accepted. Later changes to them do not alter the words driven during that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to run the sequence |
| banks_idle | input | 1 | High when every bank is precharged |
| bl_code | input | 3 | Burst length code |
| burst_il | input | 1 | Burst type, 1 = interleaved |
| cl_code | input | 3 | CAS latency code |
| dll_off | input | 1 | 1 disables the DLL |
| drv_half | input | 1 | 1 selects half drive strength |
| dll_rst | input | 1 | Request a DLL reset in the base write |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 13 | Address pins A12:A0 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle rejection pulse |

## Verification
A wait counter loaded with the wrong value shows up as the extended or base write landing a cycle early or late. That appears at the pins within TRP_CYC plus two TMRD_CYC cycles of start, so the bench compares every pin in every cycle of each sequence. A wrong next-state decision shows up as a missing or repeated command, or a done pulse that is too long, within one cycle. A fault in the capture register or the field packing shows up only in the address word of the two write cycles. To catch it, all 128 combinations of burst length code, CAS latency code and burst type are swept, and the DLL and drive bits are varied alongside them.

// File: rtl/mrs_pkg.sv
`timescale 1ns/1ps
package mrs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_WRP, ST_EXT, ST_WEXT, ST_BASE, ST_WBASE, ST_DONE
  } seq_state_t;

  typedef struct packed {
    logic [2:0] bl;
    logic       bt;
    logic [2:0] cl;
    logic       dll_off;
    logic       drv_half;
    logic       dll_rst;
  } mode_cfg_t;

  typedef struct packed {
    logic        cs_n;
    logic        ras_n;
    logic        cas_n;
    logic        we_n;
    logic [1:0]  ba;
    logic [12:0] addr;
  } ddr_cmd_t;

endpackage

// File: rtl/mrs_cfg_check.sv
`timescale 1ns/1ps
// Decodes the requested settings: legality and the two register words.
module mrs_cfg_check
  import mrs_pkg::*;
(
  input  mode_cfg_t   cfg,
  output logic        legal,
  output logic [12:0] ext_word,
  output logic [12:0] base_word
);
  logic bl_ok, cl_ok;

  always_comb begin
    bl_ok = (cfg.bl == 3'b001) || (cfg.bl == 3'b010) || (cfg.bl == 3'b011);
    cl_ok = (cfg.cl == 3'b010) || (cfg.cl == 3'b011) || (cfg.cl == 3'b110);
    legal = bl_ok && cl_ok;
    ext_word  = {11'b0, cfg.drv_half, cfg.dll_off};
    base_word = {4'b0, cfg.dll_rst, 1'b0, cfg.cl, cfg.bt, cfg.bl};
  end
endmodule

// File: rtl/mrs_seq_fsm.sv
`timescale 1ns/1ps
// Sequencing state machine with a shared gap counter.
module mrs_seq_fsm
  import mrs_pkg::*;
#(
  parameter int TRP_CYC  = 3,
  parameter int TMRD_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       accept_ok,
  output seq_state_t state,
  output logic       launch,
  output logic       busy,
  output logic       done,
  output logic       err
);
  localparam int GAP_MAX = (TRP_CYC > TMRD_CYC) ? TRP_CYC : TMRD_CYC;
  localparam int CW      = $clog2(GAP_MAX + 1);

  logic [CW-1:0] cnt;

  assign launch = (state == ST_IDLE) && start && accept_ok;
  assign busy   = (state != ST_IDLE) && (state != ST_DONE);
  assign done   = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      err   <= 1'b0;
    end else begin
      err <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (accept_ok) state <= ST_PRE;
            else           err   <= 1'b1;
          end
        end
        ST_PRE: begin
          if (TRP_CYC > 1) begin
            state <= ST_WRP;
            cnt   <= CW'(TRP_CYC - 2);
          end else begin
            state <= ST_EXT;
          end
        end
        ST_WRP: begin
          if (cnt == '0) state <= ST_EXT;
          else           cnt   <= cnt - 1'b1;
        end
        ST_EXT: begin
          if (TMRD_CYC > 1) begin
            state <= ST_WEXT;
            cnt   <= CW'(TMRD_CYC - 2);
          end else begin
            state <= ST_BASE;
          end
        end
        ST_WEXT: begin
          if (cnt == '0) state <= ST_BASE;
          else           cnt   <= cnt - 1'b1;
        end
        ST_BASE: begin
          if (TMRD_CYC > 1) begin
            state <= ST_WBASE;
            cnt   <= CW'(TMRD_CYC - 2);
          end else begin
            state <= ST_DONE;
          end
        end
        ST_WBASE: begin
          if (cnt == '0) state <= ST_DONE;
          else           cnt   <= cnt - 1'b1;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !done));

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
endmodule

// File: rtl/mrs_cmd_drive.sv
`timescale 1ns/1ps
// Maps the sequencer state to the command, bank and address pins.
module mrs_cmd_drive
  import mrs_pkg::*;
(
  input  seq_state_t  state,
  input  logic [12:0] ext_word,
  input  logic [12:0] base_word,
  output ddr_cmd_t    cmd
);
  always_comb begin
    cmd = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, ba: 2'b00, addr: 13'h0};
    case (state)
      ST_PRE: begin
        cmd.cs_n  = 1'b0;
        cmd.ras_n = 1'b0;
        cmd.we_n  = 1'b0;
        cmd.addr  = 13'h400;
      end
      ST_WRP, ST_WEXT, ST_WBASE: cmd.cs_n = 1'b0;
      ST_EXT: begin
        cmd = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0, ba: 2'b01, addr: ext_word};
      end
      ST_BASE: begin
        cmd = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0, ba: 2'b00, addr: base_word};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mrs_seq.sv
`timescale 1ns/1ps
module mrs_seq
  import mrs_pkg::*;
#(
  parameter int TRP_CYC  = 3,
  parameter int TMRD_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        banks_idle,
  input  logic [2:0]  bl_code,
  input  logic        burst_il,
  input  logic [2:0]  cl_code,
  input  logic        dll_off,
  input  logic        drv_half,
  input  logic        dll_rst,
  output logic        cs_n,
  output logic        ras_n,
  output logic        cas_n,
  output logic        we_n,
  output logic [1:0]  ba,
  output logic [12:0] addr,
  output logic        busy,
  output logic        done,
  output logic        error
);
  mode_cfg_t   req_cfg;
  logic        legal, launch;
  logic [12:0] ext_next, base_next, ext_q, base_q;
  seq_state_t  state;
  ddr_cmd_t    cmd;

  assign req_cfg = '{bl: bl_code, bt: burst_il, cl: cl_code, dll_off: dll_off,
                     drv_half: drv_half, dll_rst: dll_rst};

  mrs_cfg_check u_check (
    .cfg(req_cfg), .legal(legal), .ext_word(ext_next), .base_word(base_next)
  );

  mrs_seq_fsm #(.TRP_CYC(TRP_CYC), .TMRD_CYC(TMRD_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .accept_ok(legal && banks_idle),
    .state(state), .launch(launch), .busy(busy), .done(done), .err(error)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q  <= '0;
      base_q <= '0;
    end else if (launch) begin
      ext_q  <= ext_next;
      base_q <= base_next;
    end
  end

  mrs_cmd_drive u_drive (
    .state(state), .ext_word(ext_q), .base_word(base_q), .cmd(cmd)
  );

  assign cs_n  = cmd.cs_n;
  assign ras_n = cmd.ras_n;
  assign cas_n = cmd.cas_n;
  assign we_n  = cmd.we_n;
  assign ba    = cmd.ba;
  assign addr  = cmd.addr;

  logic mode_wr, nop_cmd, pre_cmd;
  assign mode_wr = !cs_n && !ras_n && !cas_n && !we_n;
  assign nop_cmd = !cs_n && ras_n && cas_n && we_n;
  assign pre_cmd = !cs_n && !ras_n && cas_n && !we_n;

  // R4
  mode_ba1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |-> (ba[1] == 1'b0));

  // R5
  base_after_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !ba[0]) |-> $past(nop_cmd));

  // R8
  legal_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !ba[0]) |-> ((addr[2:0] inside {3'b001, 3'b010, 3'b011}) &&
                             (addr[6:4] inside {3'b010, 3'b011, 3'b110})));

  // R9
  idle_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cmd |-> $past(banks_idle));
endmodule

// File: tb/mrs_seq_tb_top.sv
`timescale 1ns/1ps
module mrs_seq_tb_top;
  localparam int TRP  = 3;
  localparam int TMRD = 2;
  localparam int SEQ_LEN = TRP + 2 * TMRD;   // index of the done cycle

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, banks_idle = 1'b1;
  logic [2:0] bl_code = 3'b001, cl_code = 3'b010;
  logic burst_il = 1'b0, dll_off = 1'b0, drv_half = 1'b0, dll_rst = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, busy, done, error;
  logic [1:0] ba;
  logic [12:0] addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mrs_seq #(.TRP_CYC(TRP), .TMRD_CYC(TMRD)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .banks_idle(banks_idle),
    .bl_code(bl_code), .burst_il(burst_il), .cl_code(cl_code),
    .dll_off(dll_off), .drv_half(drv_half), .dll_rst(dll_rst),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .busy(busy), .done(done), .error(error)
  );

  // vector: {cs,ras,cas,we, ba[1:0], addr[12:0], busy, done, error}
  function automatic logic [21:0] pack(logic [3:0] c, logic [1:0] b, logic [12:0] a,
                                       logic bz, logic dn, logic er);
    return {c, b, a, bz, dn, er};
  endfunction

  localparam logic [3:0] C_DES = 4'b1111, C_NOP = 4'b0111, C_PRE = 4'b0010, C_MRS = 4'b0000;

  task automatic check(input logic [21:0] exp, input string tag, input int idx);
    logic [21:0] act;
    act = pack({cs_n, ras_n, cas_n, we_n}, ba, addr, busy, done, error);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, idx, act, exp);
    end
  endtask

  task automatic run_seq(input logic [2:0] bl, input logic bt, input logic [2:0] cl,
                         input logic doff, input logic dh, input logic dr, input logic bi,
                         input int poke_at, input bit scramble, input string etag);
    bit ok;
    logic [12:0] ew, bw;
    logic [21:0] exp;
    string tag;
    ok = bi && (bl inside {3'b001, 3'b010, 3'b011}) && (cl inside {3'b010, 3'b011, 3'b110});
    ew = {11'b0, dh, doff};
    bw = {4'b0, dr, 1'b0, cl, bt, bl};
    @(negedge clk);
    bl_code = bl; burst_il = bt; cl_code = cl; dll_off = doff; drv_half = dh;
    dll_rst = dr; banks_idle = bi; start = 1'b1;
    for (int i = 0; i <= SEQ_LEN + 2; i++) begin
      @(negedge clk);
      start = 1'b0;
      if (!ok) begin
        exp = pack(C_DES, 2'b00, 13'h0, 1'b0, 1'b0, (i == 0));
        tag = etag;
      end else if (i == 0) begin
        exp = pack(C_PRE, 2'b00, 13'h400, 1'b1, 1'b0, 1'b0); tag = "R2";
      end else if (i < TRP) begin
        exp = pack(C_NOP, 2'b00, 13'h0, 1'b1, 1'b0, 1'b0); tag = "R3";
      end else if (i == TRP) begin
        exp = pack(C_MRS, 2'b01, ew, 1'b1, 1'b0, 1'b0); tag = "R4";
      end else if (i < TRP + TMRD) begin
        exp = pack(C_NOP, 2'b00, 13'h0, 1'b1, 1'b0, 1'b0); tag = "R5";
      end else if (i == TRP + TMRD) begin
        exp = pack(C_MRS, 2'b00, bw, 1'b1, 1'b0, 1'b0); tag = "R5";
      end else if (i < SEQ_LEN) begin
        exp = pack(C_NOP, 2'b00, 13'h0, 1'b1, 1'b0, 1'b0); tag = "R6";
      end else if (i == SEQ_LEN) begin
        exp = pack(C_DES, 2'b00, 13'h0, 1'b0, 1'b1, 1'b0); tag = "R6";
      end else begin
        exp = pack(C_DES, 2'b00, 13'h0, 1'b0, 1'b0, 1'b0); tag = "R6";
      end
      if (poke_at >= 0 && i > poke_at) tag = scramble ? "R11" : "R10";
      check(exp, tag, i);
      if (i == poke_at) begin
        start = 1'b1;
        if (scramble) begin
          bl_code = ~bl; burst_il = ~bt; cl_code = ~cl;
          dll_off = ~doff; drv_half = ~dh; dll_rst = ~dr; banks_idle = 1'b0;
        end
      end
    end
    banks_idle = 1'b1;
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pack(C_DES, 2'b00, 13'h0, 1'b0, 1'b0, 1'b0), "R1", 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pack(C_DES, 2'b00, 13'h0, 1'b0, 1'b0, 1'b0), "R1", 1);

    // Sweep of burst length, CAS latency and burst type: R7/R8 on reserved codes
    for (int b = 0; b < 8; b++)
      for (int c = 0; c < 8; c++)
        for (int t = 0; t < 2; t++)
          run_seq(3'(b), t[0], 3'(c), b[0] ^ t[0], c[0], b[1] ^ c[1], 1'b1, -1, 1'b0,
                  (b inside {1, 2, 3}) ? "R8" : "R7");

    // R9: banks not idle
    run_seq(3'b010, 1'b0, 3'b011, 1'b0, 1'b0, 1'b1, 1'b0, -1, 1'b0, "R9");
    run_seq(3'b011, 1'b1, 3'b110, 1'b1, 1'b1, 1'b0, 1'b0, -1, 1'b0, "R9");
    // R10: start while busy
    run_seq(3'b001, 1'b0, 3'b010, 1'b0, 1'b1, 1'b0, 1'b1, 2, 1'b0, "R10");
    run_seq(3'b011, 1'b1, 3'b011, 1'b1, 1'b0, 1'b1, 1'b1, SEQ_LEN - 1, 1'b0, "R10");
    // R11: settings changed after launch
    run_seq(3'b010, 1'b1, 3'b110, 1'b0, 1'b0, 1'b1, 1'b1, 1, 1'b1, "R11");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule